// File: doc/BRIEF.md
# Stereo Digital Volume Stepper

This block sets the digital gain on each channel of a stereo audio path. Each channel receives a target attenuation code. The block decides when the applied gain moves to that target, and how it gets there. All state advances only on a one-cycle sample-frame strobe. Between strobes the outputs hold.

Three behaviours are selected by two enables, and the enables can be combined:
- **Both enables low.** The applied level jumps to the target on the next frame.
- **Ramp enabled.** The level walks toward the target by one fine step per frame.
- **Zero-cross enabled.** A change is deferred until that channel's signal crosses zero.

A deferred change has a fallback: a shared 1024-frame tick forces it through if no crossing arrives. When both enables are set, the ramp starts only once the deferred change is released.

Target codes are in 0.5 dB units. The applied level carries two extra fraction bits, so its unit is 1/8 dB and one target step equals four ramp steps. The gain multiply is done downstream. So are filtering, limiting and register access.

Top module: `vol_ctrl_top`

## Requirements
- R1: After reset every applied level (gain_o field) is 0 and every busy_o bit is 0.
- R2: With ramp_en_i=0 and zc_en_i=0, the strobe frame sets the channel's applied level to target*4, with no intermediate value.
- R3: With ramp_en_i=1, each frame moves the applied level by exactly one unit (1/8 dB) toward the released target, or leaves it unchanged once equal.
- R4: If a new target is released mid-ramp, the ramp turns toward it from the current applied level, with no jump.
- R5: With zc_en_i=1, a changed target is released only on a frame in which that channel's sample is exactly zero or has a sign bit different from the previous frame's sample. Until then the applied level holds.
- R6: With zc_en_i=1 and no crossing, a pending target is released on the second 1024-frame tick after the request. The level therefore changes no sooner than 1024 and no later than 2048 frames after the request.
- R7: Crossing detection, deferral and timeout are tracked separately per channel. A crossing on one channel does not release the other.
- R8: With both enables set, the level stays still until release, then ramps one unit per frame.
- R9: busy_o of a channel is 1 while its applied level differs from target*4, where target is the value taken at the last frame. It drops in the frame in which the two become equal.
- R10: Outside a frame strobe, gain_o and busy_o do not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe per sample frame |
| sample_i | input | NUM_CH*SAMPLE_W | Signed samples; channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| target_i | input | NUM_CH*VOL_W | Target attenuation codes, 0.5 dB units; channel c at [c*VOL_W +: VOL_W] |
| ramp_en_i | input | 1 | Enables one-unit-per-frame ramping |
| zc_en_i | input | 1 | Enables deferral to zero crossing with timeout |
| gain_o | output | NUM_CH*(VOL_W+2) | Applied level per channel, 1/8 dB units |
| busy_o | output | NUM_CH | Applied level differs from target, per channel |

## Verification
Some properties can be checked on every clock cycle. These are: the outputs hold between strobes, a ramp never moves by more than one unit per frame, and with both enables low the level lands on target*4 with busy low one cycle after the strobe. Other behaviours depend on history and can only be shown by bench scenarios. These include:
- deferral until a sign change or an exact zero;
- the 1024 to 2048 frame timeout window;
- redirection of a ramp in flight;
- keeping one channel's crossing from releasing the other.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int unsigned FRAC_W = 2;  // 1/8 dB per unit, 4 units per 0.5 dB code
  typedef enum logic [1:0] {STEP_HOLD, STEP_UP, STEP_DN, STEP_JUMP} step_e;
endpackage

// File: rtl/vol_tick_gen.sv
module vol_tick_gen #(
  parameter int unsigned TICK_FRAMES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = $clog2(TICK_FRAMES);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (frame_i) cnt_q <= (cnt_q == CNT_W'(TICK_FRAMES-1)) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = frame_i && (cnt_q == CNT_W'(TICK_FRAMES-1));
endmodule

// File: rtl/vol_zc_det.sv
module vol_zc_det #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                zc_o
);
  logic sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sign_q <= 1'b0;
    else if (frame_i) sign_q <= sample_i[SAMPLE_W-1];
  end

  assign zc_o = (sample_i == '0) || (sample_i[SAMPLE_W-1] != sign_q);
endmodule

// File: rtl/vol_chan.sv
module vol_chan
  import vol_pkg::*;
#(
  parameter int unsigned VOL_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_i,
  input  logic                    tick_i,
  input  logic                    zc_i,
  input  logic                    ramp_en_i,
  input  logic                    zc_en_i,
  input  logic [VOL_W-1:0]        target_i,
  output logic [VOL_W+FRAC_W-1:0] level_o,
  output logic                    busy_o
);
  localparam int unsigned LVL_W = VOL_W + FRAC_W;

  logic [VOL_W-1:0] goal_q, goal_d, tgt_q;
  logic [LVL_W-1:0] level_q, aim;
  logic             tick_seen_q, pending, release_now;
  step_e            step;

  assign pending     = target_i != goal_q;
  // second tick after request forces the change
  assign release_now = !zc_en_i || (pending && (zc_i || (tick_i && tick_seen_q)));
  assign goal_d      = release_now ? target_i : goal_q;
  assign aim         = {goal_d, {FRAC_W{1'b0}}};

  always_comb begin
    if (!ramp_en_i)       step = STEP_JUMP;
    else if (aim > level_q) step = STEP_UP;
    else if (aim < level_q) step = STEP_DN;
    else                  step = STEP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      goal_q      <= '0;
      tgt_q       <= '0;
      level_q     <= '0;
      tick_seen_q <= 1'b0;
    end else if (frame_i) begin
      goal_q <= goal_d;
      tgt_q  <= target_i;
      if (!pending || release_now) tick_seen_q <= 1'b0;
      else if (tick_i)             tick_seen_q <= 1'b1;
      unique case (step)
        STEP_UP:   level_q <= level_q + 1'b1;
        STEP_DN:   level_q <= level_q - 1'b1;
        STEP_JUMP: level_q <= aim;
        default:   level_q <= level_q;
      endcase
    end
  end

  assign level_o = level_q;
  assign busy_o  = level_q != {tgt_q, {FRAC_W{1'b0}}};
endmodule

// File: rtl/vol_ctrl_top.sv
module vol_ctrl_top
  import vol_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned VOL_W       = 8,
  parameter int unsigned TICK_FRAMES = 1024
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               frame_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]         sample_i,
  input  logic [NUM_CH*VOL_W-1:0]            target_i,
  input  logic                               ramp_en_i,
  input  logic                               zc_en_i,
  output logic [NUM_CH*(VOL_W+FRAC_W)-1:0]   gain_o,
  output logic [NUM_CH-1:0]                  busy_o
);
  localparam int unsigned LVL_W = VOL_W + FRAC_W;

  logic tick;

  vol_tick_gen #(.TICK_FRAMES(TICK_FRAMES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .tick_o (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic zc;

    vol_zc_det #(.SAMPLE_W(SAMPLE_W)) u_zc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .frame_i (frame_i),
      .sample_i(sample_i[c*SAMPLE_W +: SAMPLE_W]),
      .zc_o    (zc)
    );

    vol_chan #(.VOL_W(VOL_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .frame_i  (frame_i),
      .tick_i   (tick),
      .zc_i     (zc),
      .ramp_en_i(ramp_en_i),
      .zc_en_i  (zc_en_i),
      .target_i (target_i[c*VOL_W +: VOL_W]),
      .level_o  (gain_o[c*LVL_W +: LVL_W]),
      .busy_o   (busy_o[c])
    );
  end
endmodule

// File: rtl/vol_ctrl_top_chk.sv
module vol_ctrl_top_chk #(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned VOL_W    = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          frame_i,
  input logic [NUM_CH*SAMPLE_W-1:0]    sample_i,
  input logic [NUM_CH*VOL_W-1:0]       target_i,
  input logic                          ramp_en_i,
  input logic                          zc_en_i,
  input logic [NUM_CH*(VOL_W+2)-1:0]   gain_o,
  input logic [NUM_CH-1:0]             busy_o
);
  localparam int unsigned LVL_W = VOL_W + 2;

  a_r10_hold_between_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> ($stable(gain_o) && $stable(busy_o)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r3_single_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_i && ramp_en_i |=>
        (gain_o[c*LVL_W +: LVL_W] == $past(gain_o[c*LVL_W +: LVL_W])) ||
        (gain_o[c*LVL_W +: LVL_W] == LVL_W'($past(gain_o[c*LVL_W +: LVL_W]) + 1'b1)) ||
        ($past(gain_o[c*LVL_W +: LVL_W]) == LVL_W'(gain_o[c*LVL_W +: LVL_W] + 1'b1)));

    a_r2_direct_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_i && !ramp_en_i && !zc_en_i |=>
        gain_o[c*LVL_W +: LVL_W] == {$past(target_i[c*VOL_W +: VOL_W]), 2'b00});

    a_r9_direct_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_i && !ramp_en_i && !zc_en_i |=> !busy_o[c]);
  end
endmodule

bind vol_ctrl_top vol_ctrl_top_chk #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W)
) u_chk (.*);

// File: tb/vol_ctrl_top_tb.sv
module vol_ctrl_top_tb;
  localparam int NC = 2;
  localparam int SW = 16;
  localparam int VW = 8;
  localparam int LW = VW + 2;
  localparam int TF = 1024;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               frame_i = 1'b0;
  logic [NC*SW-1:0]   sample_i = '0;
  logic [NC*VW-1:0]   target_i = '0;
  logic               ramp_en_i = 1'b0;
  logic               zc_en_i = 1'b0;
  logic [NC*LW-1:0]   gain_o;
  logic [NC-1:0]      busy_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_cnt = 0;
  int m_goal[NC];
  int m_app[NC];
  int m_tgt[NC];
  bit m_sign[NC];
  bit m_tk[NC];

  always #2.5 clk_i = ~clk_i;

  vol_ctrl_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .sample_i(sample_i),
    .target_i(target_i), .ramp_en_i(ramp_en_i), .zc_en_i(zc_en_i),
    .gain_o(gain_o), .busy_o(busy_o)
  );

  function automatic int gain_of(int c);
    return int'(gain_o[c*LW +: LW]);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(int s[NC], int t[NC], bit rmp, bit zce);
    bit tick;
    tick = (m_cnt == TF - 1);
    m_cnt = (m_cnt + 1) % TF;
    for (int c = 0; c < NC; c++) begin
      bit sg, pend, zc, rel;
      int aim;
      sg   = s[c] < 0;
      pend = t[c] != m_goal[c];
      zc   = (s[c] == 0) || (sg != m_sign[c]);
      rel  = !zce || (pend && (zc || (tick && m_tk[c])));
      if (!pend || rel) m_tk[c] = 0;
      else if (tick)    m_tk[c] = 1;
      if (rel) m_goal[c] = t[c];
      aim = m_goal[c] * 4;
      if (!rmp) m_app[c] = aim;
      else if (aim > m_app[c]) m_app[c]++;
      else if (aim < m_app[c]) m_app[c]--;
      m_sign[c] = sg;
      m_tgt[c]  = t[c];
    end
  endtask

  // one frame: strobe, then compare at the following negedge
  task automatic frame(int s0, int s1, int t0, int t1, bit rmp, bit zce, string req);
    int s[NC];
    int t[NC];
    s[0] = s0; s[1] = s1; t[0] = t0; t[1] = t1;
    @(negedge clk_i);
    sample_i  = {SW'(s1), SW'(s0)};
    target_i  = {VW'(t1), VW'(t0)};
    ramp_en_i = rmp;
    zc_en_i   = zce;
    frame_i   = 1'b1;
    @(negedge clk_i);
    frame_i = 1'b0;
    model_step(s, t, rmp, zce);
    for (int c = 0; c < NC; c++) begin
      check(req, gain_of(c), m_app[c]);
      check(req, int'(busy_o[c]), int'(m_app[c] != m_tgt[c] * 4));
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int n;
    int sgn0, sgn1;
    bit rmp, zce;
    void'($urandom(32'd4242));
    for (int c = 0; c < NC; c++) begin
      m_goal[c] = 0; m_app[c] = 0; m_tgt[c] = 0; m_sign[c] = 0; m_tk[c] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      check("R1", gain_of(c), 0);
      check("R1", int'(busy_o[c]), 0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 direct jump
    frame(100, 100, 40, 100, 0, 0, "R2");
    check("R2", gain_of(0), 160);
    check("R2", gain_of(1), 400);

    // R3 ramp up and down by one unit per frame; R9 busy during ramp
    frame(100, 100, 42, 99, 1, 0, "R3");
    check("R3", gain_of(0), 161);
    check("R9", int'(busy_o[0]), 1);
    for (int i = 0; i < 7; i++) frame(100, 100, 42, 99, 1, 0, "R3");
    check("R3", gain_of(0), 168);
    check("R9", int'(busy_o[0]), 0);
    check("R3", gain_of(1), 396);

    // R10 inputs move between strobes, outputs hold
    @(negedge clk_i);
    target_i = '1; sample_i = '0; ramp_en_i = 0; zc_en_i = 0;
    repeat (3) @(negedge clk_i);
    check("R10", gain_of(0), 168);
    check("R10", int'(busy_o[0]), 0);

    // R4 redirect mid-ramp from current level
    for (int i = 0; i < 5; i++) frame(100, 100, 60, 99, 1, 0, "R4");
    check("R4", gain_of(0), 173);
    frame(100, 100, 30, 99, 1, 0, "R4");
    check("R4", gain_of(0), 172);

    // settle, then R5/R7 zero-cross deferral
    frame(100, 100, 20, 20, 0, 0, "R2");
    for (int i = 0; i < 6; i++) frame(100, 100, 50, 50, 0, 1, "R5");
    check("R5", gain_of(0), 80);
    check("R5", int'(busy_o[0]), 1);
    frame(-5, 100, 50, 50, 0, 1, "R7");
    check("R7", gain_of(0), 200);
    check("R7", gain_of(1), 80);
    frame(-5, 0, 50, 50, 0, 1, "R5");
    check("R5", gain_of(1), 200);

    // R8 both modes: hold then ramp
    for (int i = 0; i < 4; i++) frame(-5, 3, 52, 52, 1, 1, "R8");
    check("R8", gain_of(0), 200);
    frame(7, 3, 52, 52, 1, 1, "R8");
    check("R8", gain_of(0), 201);
    check("R8", gain_of(1), 200);
    for (int i = 0; i < 8; i++) frame(7, 3, 52, 52, 1, 1, "R8");
    check("R8", gain_of(0), 208);

    // R6 timeout with no crossing on either channel
    frame(7, 3, 10, 10, 0, 0, "R2");
    n = 0;
    while (gain_of(0) == 40 && n < 2100) begin
      frame(7, 3, 90, 90, 0, 1, "R6");
      n++;
    end
    checks++;
    if (n < TF || n > 2 * TF) begin
      failures++;
      $display("FAIL R6 actual=%0d expected=1024..2048 frames", n);
    end
    check("R6", gain_of(1), 360);

    // R7 randomized mix of modes, signs and targets
    sgn0 = 1; sgn1 = 1;
    rmp = 0; zce = 0;
    for (int i = 0; i < 1500; i++) begin
      int s0, s1, t0, t1;
      if (i % 50 == 0) begin
        rmp = $urandom_range(0, 1);
        zce = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 15) == 0) sgn0 = -sgn0;
      if ($urandom_range(0, 15) == 0) sgn1 = -sgn1;
      s0 = ($urandom_range(0, 31) == 0) ? 0 : sgn0 * int'($urandom_range(1, 30000));
      s1 = ($urandom_range(0, 31) == 0) ? 0 : sgn1 * int'($urandom_range(1, 30000));
      t0 = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 255)) : m_tgt[0];
      t1 = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 255)) : m_tgt[1];
      frame(s0, s1, t0, t1, rmp, zce, "R7");
      if ($urandom_range(0, 9) == 0) begin
        target_i = VW'($urandom) ; sample_i = '0;
        repeat (2) @(negedge clk_i);
        check("R10", gain_of(0), m_app[0]);
        check("R10", gain_of(1), m_app[1]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule